// File: doc/BRIEF.md
# Paged byte-write sequencer for a parallel EEPROM

This block is the memory-side control logic of a small byte-wide parallel EEPROM. It samples the active-low chip select, write strobe and output enable on one system clock, together with an address bus and a data bus. A host writes a byte by pulling both chip select and write strobe low while output enable stays high. The address is taken when the later of the two strobes falls. The data is taken when the first of the two rises.

Accepted bytes collect in a page buffer. A load timer restarts after every accepted byte. When the timer runs out, a self-timed programming cycle begins. At the end of that cycle, the buffered bytes are written into the storage array in one step. During that cycle, write strobes are ignored.

A separate status block builds its polling bits from the busy, load-timer-running, last-address and last-data outputs. After reset the array reads as all ones. Reads become available after a short delay. Writes are refused for a longer power-up window.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write is recognised only while ce_n and we_n are both low and oe_n is high. A strobe made with oe_n low loads nothing and leaves the array unchanged.
- R2: The byte address is the value on addr when the write condition first becomes true, meaning the later falling edge of ce_n and we_n. Changes to addr after that point do not move the byte.
- R3: The stored data is the value on din when the write condition ends, meaning the first rising edge of ce_n or we_n. Earlier values on din are not stored.
- R4: One page load holds up to 2^PAGE_W bytes (32 by default), all sharing addr[ADDR_W-1:PAGE_W]. A byte whose page bits differ from the first byte of the load is discarded. A discarded byte does not restart the load timer and does not update last_addr or last_data.
- R5: A second write to the same offset within one load replaces the earlier value. Only offsets written during the load are committed. Every other array location keeps its contents.
- R6: Each accepted byte restarts the load timer, and load_active is high while it runs. busy rises LOAD_CYC+3 clock edges after the strobe that ended the last accepted byte rises at the pins.
- R7: The programming cycle lasts PROG_CYC clock cycles, with busy high and load_active low. Write strobes during it are ignored. The array takes the page at the edge where busy falls.
- R8: After reset, writes are ignored for PWRUP_CYC cycles. Reads return nothing (dout_en low) until READ_CYC cycles after reset.
- R9: Every array location reads 8'hFF after reset.
- R10: A read (ce_n and oe_n low, we_n high) drives dout with the addressed byte and sets dout_en on the third clock edge after the pins change. dout_en is low otherwise.
- R11: last_addr and last_data hold the address and data of the most recently accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the upper ADDR_W-PAGE_W bits select the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | High while dout carries read data |
| busy | output | 1 | Programming cycle in progress |
| load_active | output | 1 | Load timer running |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
Every strobe passes through two synchroniser flops. A captured byte therefore takes effect on the third edge after the pins move, and a read result appears on that same third edge. busy rises LOAD_CYC+3 edges after the last accepted strobe ends, and falls PROG_CYC edges after that. The bench keeps a free-running edge counter and records its value when it releases each strobe. It then polls busy on falling clock edges and compares the edge count at which busy changes against these exact sums. This check also shows that a foreign-page byte leaves the timer running. Read and write tasks hold the bus one or more cycles beyond these delays and sample only on falling edges.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    SQ_PWRUP = 2'd0,
    SQ_IDLE  = 2'd1,
    SQ_LOAD  = 2'd2,
    SQ_PROG  = 2'd3
  } sq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pw_strobe_sync.sv
module pw_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end,
  output logic rd_sel
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] synced;
  logic ce_s, we_s, oe_s;
  logic wr_act, wr_act_q;

  assign raw = {ce_n, we_n, oe_n};

  // Strobes cross into the clock domain through a flop chain, idle high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign synced = chain[STAGES-1];
  assign ce_s   = synced[2];
  assign we_s   = synced[1];
  assign oe_s   = synced[0];

  // Write condition: both strobes low while the output driver is off.
  assign wr_act = ~ce_s & ~we_s & oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  // Start: the later falling strobe. End: the first rising strobe, with oe_n still high.
  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = wr_act_q & ~wr_act & oe_s;
  assign rd_sel   = ~ce_s & ~oe_s & we_s;
endmodule

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [PAGE_W-1:0]                   wr_off,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                clear,
  input  logic                                busy,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  data_q,
  output logic [(1<<PAGE_W)-1:0]              valid_q
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_ent
      logic              hit;
      logic [DATA_W-1:0] d_r;
      logic              v_r;

      assign hit = wr_en && (wr_off == PAGE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_r <= '0;
          v_r <= 1'b0;
        end else begin
          if (hit) d_r <= wr_data;
          if (clear)    v_r <= 1'b0;
          else if (hit) v_r <= 1'b1;
        end
      end

      assign data_q[g]  = d_r;
      assign valid_q[g] = v_r;
    end
  endgenerate

  // R7: the buffer is frozen for the whole programming cycle.
  a_r7_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(valid_q));

  // R5: a commit always carries at least one loaded byte.
  a_r5_commit_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> (valid_q != '0));
endmodule

// File: rtl/pw_write_seq.sv
module pw_write_seq
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int DATA_W    = 8,
  parameter int LOAD_CYC  = 20,
  parameter int PROG_CYC  = 50,
  parameter int PWRUP_CYC = 60,
  parameter int READ_CYC  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_start,
  input  logic                     wr_end,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  output logic                     accept,
  output logic [PAGE_W-1:0]        acc_off,
  output logic [DATA_W-1:0]        acc_data,
  output logic                     commit,
  output logic [ADDR_W-PAGE_W-1:0] page_q,
  output logic                     busy,
  output logic                     load_active,
  output logic                     read_ok,
  output logic [ADDR_W-1:0]        last_addr,
  output logic [DATA_W-1:0]        last_data
);
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(max4(LOAD_CYC, PROG_CYC, PWRUP_CYC, READ_CYC) + 1);

  sq_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0]  page_d;
  logic [ADDR_W-1:0] addr_lat;
  logic              read_ok_d;
  logic              same_page;

  // R2: address is held from the start of the write condition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_lat <= '0;
    else if (wr_start) addr_lat <= addr;
  end

  assign same_page = (addr_lat[ADDR_W-1:PAGE_W] == page_q);
  assign accept    = wr_end && ((state_q == SQ_IDLE) || ((state_q == SQ_LOAD) && same_page));
  assign acc_off   = addr_lat[PAGE_W-1:0];
  assign acc_data  = din;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    page_d    = page_q;
    read_ok_d = read_ok;
    commit    = 1'b0;
    case (state_q)
      SQ_PWRUP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q >= CNT_W'(READ_CYC - 1)) read_ok_d = 1'b1;
        if (cnt_q == CNT_W'(PWRUP_CYC - 1)) begin
          state_d   = SQ_IDLE;
          cnt_d     = '0;
          read_ok_d = 1'b1;
        end
      end
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_LOAD;
          cnt_d   = '0;
          page_d  = addr_lat[ADDR_W-1:PAGE_W];
        end
      end
      SQ_LOAD: begin
        if (accept) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(LOAD_CYC - 1)) begin
          state_d = SQ_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
          commit  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_PWRUP;
      cnt_q   <= '0;
      page_q  <= '0;
      read_ok <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      page_q  <= page_d;
      read_ok <= read_ok_d;
    end
  end

  // R11: report the last byte actually taken into the buffer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (accept) begin
      last_addr <= addr_lat;
      last_data <= din;
    end
  end

  assign busy        = (state_q == SQ_PROG);
  assign load_active = (state_q == SQ_LOAD);

  // R6: a page load only ever ends by entering programming.
  a_r6_load_ends_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_active) |-> busy);

  // R8: no page load can open before the power-up window has let reads in.
  a_r8_no_load_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !read_ok |-> !load_active);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int LOAD_CYC  = 20,
  parameter int PROG_CYC  = 50,
  parameter int PWRUP_CYC = 60,
  parameter int READ_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy,
  output logic              load_active,
  output logic [ADDR_W-1:0] last_addr,
  output logic [7:0]        last_data
);
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [1:0]                          rst_sync_q;
  logic                                rst_i;
  logic                                wr_start, wr_end, rd_sel;
  logic                                accept, commit, read_ok;
  logic [PAGE_W-1:0]                   acc_off;
  logic [DATA_W-1:0]                   acc_data;
  logic [TAG_W-1:0]                    page_lat;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]   buf_data;
  logic [PAGE_BYTES-1:0]               buf_valid;
  logic [DATA_W-1:0]                   mem [DEPTH];
  logic                                rd_en;

  // Reset asserts at once and leaves through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  pw_strobe_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .wr_start (wr_start),
    .wr_end   (wr_end),
    .rd_sel   (rd_sel)
  );

  pw_write_seq #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .DATA_W    (DATA_W),
    .LOAD_CYC  (LOAD_CYC),
    .PROG_CYC  (PROG_CYC),
    .PWRUP_CYC (PWRUP_CYC),
    .READ_CYC  (READ_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_i),
    .wr_start    (wr_start),
    .wr_end      (wr_end),
    .addr        (addr),
    .din         (din),
    .accept      (accept),
    .acc_off     (acc_off),
    .acc_data    (acc_data),
    .commit      (commit),
    .page_q      (page_lat),
    .busy        (busy),
    .load_active (load_active),
    .read_ok     (read_ok),
    .last_addr   (last_addr),
    .last_data   (last_data)
  );

  pw_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (accept),
    .wr_off  (acc_off),
    .wr_data (acc_data),
    .clear   (commit),
    .busy    (busy),
    .data_q  (buf_data),
    .valid_q (buf_valid)
  );

  // R9 erased state; R5/R7 whole-page commit at the end of programming.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (buf_valid[i]) mem[{page_lat, PAGE_W'(i)}] <= buf_data[i];
      end
    end
  end

  // R10: registered read port.
  assign rd_en = rd_sel & read_ok;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= rd_en ? mem[addr] : '0;
      dout_en <= rd_en;
    end
  end

  // R4: the page under load never changes while loading continues.
  a_r4_page_steady: assert property (@(posedge clk) disable iff (!rst_i)
    (load_active && $past(load_active)) |-> $stable(page_lat));

  // R10: read data is only presented once reads have been released.
  a_r10_read_after_ready: assert property (@(posedge clk) disable iff (!rst_i)
    dout_en |-> $past(read_ok));
endmodule

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int PAGE_W     = 5;
  localparam int LOAD_CYC   = 20;
  localparam int PROG_CYC   = 50;
  localparam int PWRUP_CYC  = 60;
  localparam int READ_CYC   = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, we_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        din;
  logic [7:0]        dout;
  logic              dout_en, busy, load_active;
  logic [ADDR_W-1:0] last_addr;
  logic [7:0]        last_data;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC),
    .PROG_CYC(PROG_CYC), .PWRUP_CYC(PWRUP_CYC), .READ_CYC(READ_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
    .load_active(load_active), .last_addr(last_addr), .last_data(last_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One byte write; t_end is the edge count when the ending strobe rises.
  task automatic write_byte(input logic [7:0] a, input logic [7:0] d,
                            input bit ce_ctrl, input bit oe_low, output int t_end);
    @(negedge clk);
    addr = a; din = ~d; oe_n = oe_low ? 1'b0 : 1'b1;
    if (ce_ctrl) begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
    else         begin ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
    repeat (4) @(negedge clk);
    addr = a ^ 8'h01; din = d;
    repeat (2) @(negedge clk);
    t_end = cyc;
    if (ce_ctrl) ce_n = 1'b1; else we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_busy(input logic lvl, output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      if (busy === lvl) begin t = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_byte(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d; logic en;
    read_byte(a, d, en);
    check(req, en, 1'b1);
    check(req, d, exp);
  endtask

  task automatic t_reset_powerup();
    int t; logic [7:0] d; logic en;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    repeat (4) @(negedge clk);
    check("R6 reset load_active", load_active, 1'b0);
    check("R7 reset busy", busy, 1'b0);
    rst_n = 1'b1; addr = 8'h10; ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 no read before delay", dout_en, 1'b0);
    repeat (8) @(negedge clk);
    check("R8 read after delay", dout_en, 1'b1);
    check("R9 erased value", dout, 8'hFF);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    write_byte(8'h10, 8'h3C, 1'b0, 1'b0, t);
    check("R8 write inhibited at power-up", load_active, 1'b0);
    repeat (PWRUP_CYC + 20) @(negedge clk);
    check("R8 no programming from power-up write", busy, 1'b0);
    read_byte(8'h10, d, en);
    check("R8 power-up write discarded", d, 8'hFF);
    expect_byte("R9 erased high address", 8'hFF, 8'hFF);
  endtask

  task automatic t_single_byte();
    int t0, t1, tr, tf;
    write_byte(8'h05, 8'hA5, 1'b0, 1'b0, t0);
    check("R11 last_addr", last_addr, 8'h05);
    check("R11 last_data", last_data, 8'hA5);
    check("R6 timer running", load_active, 1'b1);
    wait_busy(1'b1, tr);
    check("R6 busy rise edge", tr, t0 + 3 + LOAD_CYC);
    check("R7 load_active low while busy", load_active, 1'b0);
    write_byte(8'h07, 8'h11, 1'b0, 1'b0, t1);
    check("R7 strobe ignored while busy", last_addr, 8'h05);
    wait_busy(1'b0, tf);
    check("R7 busy fall edge", tf, t0 + 3 + LOAD_CYC + PROG_CYC);
    check("R7 no load after ignored strobe", load_active, 1'b0);
    expect_byte("R3 data taken at strobe end", 8'h05, 8'hA5);
    expect_byte("R2 address taken at strobe start", 8'h04, 8'hFF);
    expect_byte("R7 ignored byte not stored", 8'h07, 8'hFF);
  endtask

  task automatic t_oe_inhibit();
    int t;
    write_byte(8'h50, 8'h77, 1'b0, 1'b1, t);
    check("R1 oe low blocks load", load_active, 1'b0);
    repeat (LOAD_CYC + PROG_CYC + 10) @(negedge clk);
    check("R1 oe low no programming", busy, 1'b0);
    expect_byte("R1 oe low array unchanged", 8'h50, 8'hFF);
  endtask

  task automatic t_page_load();
    int ta, tb, tc, tlast, tf, tr, tfall;
    write_byte(8'h20, 8'h11, 1'b0, 1'b0, ta);
    write_byte(8'h22, 8'h22, 1'b1, 1'b0, tb);
    write_byte(8'h3C, 8'h33, 1'b0, 1'b0, tc);
    write_byte(8'h22, 8'h99, 1'b0, 1'b0, tlast);
    check("R6 timer restarted by each byte", busy, 1'b0);
    check("R6 still loading past one window", load_active, 1'b1);
    write_byte(8'h45, 8'h44, 1'b1, 1'b0, tf);
    check("R4 foreign byte not reported addr", last_addr, 8'h22);
    check("R4 foreign byte not reported data", last_data, 8'h99);
    wait_busy(1'b1, tr);
    check("R4 foreign byte does not restart timer", tr, tlast + 3 + LOAD_CYC);
    wait_busy(1'b0, tfall);
    check("R7 page program length", tfall, tr + PROG_CYC);
    expect_byte("R4 first byte of page", 8'h20, 8'h11);
    expect_byte("R5 overwrite keeps last value", 8'h22, 8'h99);
    expect_byte("R4 page top byte", 8'h3C, 8'h33);
    expect_byte("R4 foreign page byte discarded", 8'h45, 8'hFF);
    expect_byte("R5 unwritten offset untouched", 8'h21, 8'hFF);
    expect_byte("R5 earlier page kept", 8'h05, 8'hA5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_powerup();
    t_single_byte();
    t_oe_inhibit();
    t_page_load();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule